// File: doc/BRIEF.md
# Counter measurement cycle sequencer

This block runs the gating cycle of an automatic, repetitive event counter. Each measurement follows the same order. A one-cycle clear pulse goes to the counting decades and to the divide-by-ten prescaler. A fixed settling interval follows, and then the counted-signal gate opens. When the gate closes, a programmable display-hold interval begins. While the hold runs, further trigger pulses cannot start a new count, so the last result stays on the display.

There are two modes. In automatic mode, one trigger input both opens and closes the gate. In time-interval mode, separate start and stop channels open and close the gate. A manual clear request produces the same clear pulse as the automatic cycle. It also aborts any measurement or hold in progress and leaves the gate closed.

All pulse inputs pass through a synchronizer and are then edge-detected. A level that stays high acts only once.

Top module: `cnt_cycle_seq`

## Requirements
- R1: While reset is asserted and after it is released, `gate_o`, `dec_reset_o` and `presc_reset_o` are low.
- R2: During the display hold, trigger pulses have no effect: `dec_reset_o` stays low and `gate_o` stays closed.
- R3: The hold lasts exactly `hold_len_i` cycles after the closing event. An opening pulse sampled in the hold's last cycle is ignored. One sampled a cycle later starts a measurement.
- R4: An opening event produces a `dec_reset_o` pulse exactly one cycle wide. It goes high SYNC_STAGES+1 rising edges after the input is first sampled high, which is 3 edges with the defaults.
- R5: `gate_o` rises exactly SETTLE_CYC+1 cycles after `dec_reset_o` rises, where SETTLE_CYC = (CLK_HZ/1e6)*SETTLE_US.
- R6: In automatic mode (`mode_interval_i`=0), a trigger while the gate is open closes it with the same input latency as R4. No clear pulse is produced.
- R7: `presc_reset_o` is high in every cycle in which `dec_reset_o` is high.
- R8: With `hold_len_i`=0, there is no hold. A trigger applied right after the gate closes starts a new measurement.
- R9: A manual clear gives a `dec_reset_o` pulse with R4 latency and closes the gate. It aborts any settle or hold in progress and returns the block to idle.
- R10: In time-interval mode (`mode_interval_i`=1), a start pulse opens the gate through the clear and settle steps, and a stop pulse closes it. The trigger input is ignored. A start pulse while a measurement is running is ignored.
- R11: A stop pulse while the gate is closed, including one before any start, has no effect.
- R12: Inputs are edge-sensitive. A trigger held high for many cycles starts one measurement only and does not close the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_interval_i | input | 1 | 0 = automatic trigger mode, 1 = time-interval mode |
| trig_i | input | 1 | Trigger pulse, automatic mode |
| start_i | input | 1 | Start channel pulse, time-interval mode |
| stop_i | input | 1 | Stop channel pulse, time-interval mode |
| man_reset_i | input | 1 | Manual clear request |
| hold_len_i | input | HOLD_W | Display-hold length in cycles, sampled when the gate closes |
| gate_o | output | 1 | Counted-signal gate enable |
| dec_reset_o | output | 1 | Clear pulse to the counting decades |
| presc_reset_o | output | 1 | Clear pulse to the divide-by-ten prescaler |

## Verification
The sequencer has little state, and a fault in it shows up at the ports within one measurement. A wrong settle counter moves the gate's rising edge off its fixed distance from the clear pulse. A bad hold count or a missing trigger mask either lets a clear pulse through during the hold or rejects the first trigger after it. The bench therefore measures these distances to the exact cycle at the boundaries. A stuck edge detector shows up as a gate closed by a held level, and a broken abort as a gate still open after a manual clear.

// File: rtl/cnt_seq_pkg.sv
package cnt_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLEAR  = 3'd1,
    ST_SETTLE = 3'd2,
    ST_GATE   = 3'd3,
    ST_HOLD   = 3'd4
  } seq_state_e;

  localparam int unsigned CH_TRIG  = 0;
  localparam int unsigned CH_START = 1;
  localparam int unsigned CH_STOP  = 2;
  localparam int unsigned CH_MAN   = 3;
  localparam int unsigned N_CH     = 4;

endpackage

// File: rtl/cnt_seq_edge.sv
module cnt_seq_edge #(
  parameter int unsigned N_CH        = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] in_i,
  output logic [N_CH-1:0] pulse_o
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q[0] <= in_i[ch];
        for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
        prev_q <= sync_q[LAST];
      end
    end

    assign pulse_o[ch] = sync_q[LAST] & ~prev_q;
  end

endmodule

// File: rtl/cnt_seq_settle_timer.sv
module cnt_seq_settle_timer #(
  parameter int unsigned SETTLE_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST_CNT);

endmodule

// File: rtl/cnt_seq_hold_timer.sv
module cnt_seq_hold_timer #(
  parameter int unsigned HOLD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [HOLD_W-1:0] len_i,
  output logic              active_o,
  output logic              expire_o
);

  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clear_i)   cnt_q <= '0;
    else if (load_i)    cnt_q <= len_i;
    else if (active_o)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
  assign expire_o = (cnt_q == HOLD_W'(1));

endmodule

// File: rtl/cnt_seq_fsm.sv
module cnt_seq_fsm
  import cnt_seq_pkg::*;
#(
  parameter int unsigned HOLD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_interval_i,
  input  logic              trig_p_i,
  input  logic              start_p_i,
  input  logic              stop_p_i,
  input  logic              man_p_i,
  input  logic [HOLD_W-1:0] hold_len_i,
  input  logic              settle_done_i,
  input  logic              hold_expire_i,
  output logic              settle_run_o,
  output logic              hold_load_o,
  output logic              gate_o,
  output logic              dec_reset_o,
  output logic              presc_reset_o
);

  seq_state_e state_q, state_d;
  logic       man_q;
  logic       open_ev, close_ev;

  assign open_ev  = mode_interval_i ? start_p_i : trig_p_i;
  assign close_ev = mode_interval_i ? stop_p_i  : trig_p_i;

  always_comb begin
    state_d     = state_q;
    hold_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (open_ev) state_d = ST_CLEAR;
      ST_CLEAR:  state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done_i) state_d = ST_GATE;
      ST_GATE: begin
        if (close_ev) begin
          hold_load_o = 1'b1;
          state_d     = (hold_len_i == '0) ? ST_IDLE : ST_HOLD;
        end
      end
      ST_HOLD:   if (hold_expire_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    // manual clear wins over every transition
    if (man_p_i) begin
      state_d     = ST_IDLE;
      hold_load_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      man_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      man_q   <= man_p_i;
    end
  end

  assign settle_run_o  = (state_q == ST_SETTLE);
  assign gate_o        = (state_q == ST_GATE);
  assign dec_reset_o   = (state_q == ST_CLEAR) | man_q;
  assign presc_reset_o = (state_q == ST_CLEAR) | man_q;

endmodule

// File: rtl/cnt_cycle_seq.sv
module cnt_cycle_seq
  import cnt_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned SETTLE_US   = 20,
  parameter int unsigned HOLD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_interval_i,
  input  logic              trig_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              man_reset_i,
  input  logic [HOLD_W-1:0] hold_len_i,
  output logic              gate_o,
  output logic              dec_reset_o,
  output logic              presc_reset_o
);

  localparam int unsigned SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;

  logic [N_CH-1:0] raw_in, pulses;
  logic            settle_run, settle_done;
  logic            hold_load, hold_active, hold_expire;

  assign raw_in[CH_TRIG]  = trig_i;
  assign raw_in[CH_START] = start_i;
  assign raw_in[CH_STOP]  = stop_i;
  assign raw_in[CH_MAN]   = man_reset_i;

  cnt_seq_edge #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (raw_in),
    .pulse_o(pulses)
  );

  cnt_seq_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (settle_run),
    .done_o(settle_done)
  );

  cnt_seq_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (hold_load),
    .clear_i (pulses[CH_MAN]),
    .len_i   (hold_len_i),
    .active_o(hold_active),
    .expire_o(hold_expire)
  );

  cnt_seq_fsm #(.HOLD_W(HOLD_W)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_interval_i(mode_interval_i),
    .trig_p_i       (pulses[CH_TRIG]),
    .start_p_i      (pulses[CH_START]),
    .stop_p_i       (pulses[CH_STOP]),
    .man_p_i        (pulses[CH_MAN]),
    .hold_len_i     (hold_len_i),
    .settle_done_i  (settle_done),
    .hold_expire_i  (hold_expire),
    .settle_run_o   (settle_run),
    .hold_load_o    (hold_load),
    .gate_o         (gate_o),
    .dec_reset_o    (dec_reset_o),
    .presc_reset_o  (presc_reset_o)
  );

endmodule

// File: rtl/cnt_seq_checker.sv
module cnt_seq_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic gate_i,
  input logic dec_reset_i,
  input logic presc_reset_i,
  input logic settle_done_i,
  input logic hold_active_i,
  input logic man_pulse_i
);

  assert_gate_after_settle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_i) |-> $past(settle_done_i));

  assert_gate_shut_in_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_reset_i |-> !gate_i);

  assert_presc_with_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_reset_i |-> presc_reset_i);

  assert_hold_masks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_active_i && !man_pulse_i) |=> (!dec_reset_i && !gate_i));

  assert_manual_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_pulse_i |=> (dec_reset_i && !gate_i && !hold_active_i));

endmodule

bind cnt_cycle_seq cnt_seq_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .gate_i       (gate_o),
  .dec_reset_i  (dec_reset_o),
  .presc_reset_i(presc_reset_o),
  .settle_done_i(settle_done),
  .hold_active_i(hold_active),
  .man_pulse_i  (pulses[3])
);

// File: tb/cnt_cycle_seq_bench.sv
module cnt_cycle_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SC         = 20;   // 1 MHz * 20 us
  localparam int LAT        = 3;    // SYNC_STAGES + 1
  localparam int HW         = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_interval = 1'b0;
  logic trig = 1'b0, start = 1'b0, stop = 1'b0, man_rst = 1'b0;
  logic [HW-1:0] hold_len = '0;
  logic gate, dec_rst, presc_rst;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnt_cycle_seq #(.CLK_HZ(1_000_000), .SETTLE_US(20), .HOLD_W(HW), .SYNC_STAGES(2)) u_cnt_cycle_seq (
    .clk_i(clk), .rst_ni(rst_n), .mode_interval_i(mode_interval),
    .trig_i(trig), .start_i(start), .stop_i(stop), .man_reset_i(man_rst),
    .hold_len_i(hold_len), .gate_o(gate), .dec_reset_o(dec_rst), .presc_reset_o(presc_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // channel: 0 trig, 1 start, 2 stop, 3 manual; called at a negedge
  task automatic fire(input int ch);
    case (ch)
      0: trig = 1'b1;
      1: start = 1'b1;
      2: stop = 1'b1;
      default: man_rst = 1'b1;
    endcase
  endtask

  // which: 0 dec_rst high, 1 gate high, 2 gate low
  task automatic wait_sig(input int which, input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      {trig, start, stop, man_rst} = '0;
      if ((which == 0 && dec_rst) || (which == 1 && gate) || (which == 2 && !gate)) break;
    end
  endtask

  task automatic count_dec(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      {trig, start, stop, man_rst} = '0;
      if (dec_rst) hits++;
    end
  endtask

  task automatic open_meas(input int ch);
    int n;
    fire(ch);
    wait_sig(0, 10, n);
    chk(n == LAT, "R4 clear latency", n, LAT);
    chk(presc_rst == 1'b1, "R7 prescaler clear", presc_rst, 1);
    @(negedge clk);
    chk(dec_rst == 1'b0, "R4 clear width", dec_rst, 0);
    wait_sig(1, SC + 10, n);
    chk(n + 1 == SC + 1, "R5 settle delay", n + 1, SC + 1);
  endtask

  task automatic close_meas(input int ch);
    int n;
    fire(ch);
    wait_sig(2, 10, n);
    chk(n == LAT, "R6 close latency", n, LAT);
    chk(dec_rst == 1'b0, "R6 no clear on close", dec_rst, 0);
  endtask

  task automatic t_reset;
    #(CLK_PERIOD*2);
    chk(!gate && !dec_rst && !presc_rst, "R1 in reset", {gate, dec_rst, presc_rst}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!gate && !dec_rst && !presc_rst, "R1 after reset", {gate, dec_rst, presc_rst}, 0);
  endtask

  task automatic t_auto;
    mode_interval = 1'b0; hold_len = 0;
    open_meas(0);
    repeat (30) @(negedge clk);
    chk(gate == 1'b1, "R6 gate held open", gate, 1);
    close_meas(0);
  endtask

  task automatic t_hold;
    int n, hits;
    mode_interval = 1'b0; hold_len = 12;
    open_meas(0);
    close_meas(0);
    repeat (12 - 3) @(negedge clk);
    fire(0);  // sampled in the last hold cycle
    count_dec(15, hits);
    chk(hits == 0, "R2 R3 trigger in last hold cycle", hits, 0);
    chk(gate == 1'b0, "R2 gate stays shut", gate, 0);
    open_meas(0);
    close_meas(0);
    repeat (12 - 2) @(negedge clk);
    fire(0);  // sampled one cycle after hold ends
    wait_sig(0, 10, n);
    chk(n == LAT, "R3 trigger after hold", n, LAT);
    wait_sig(1, SC + 10, n);
    hold_len = 0;
    close_meas(0);
  endtask

  task automatic t_hold_zero;
    int n;
    mode_interval = 1'b0; hold_len = 0;
    open_meas(0);
    close_meas(0);
    fire(0);
    wait_sig(0, 10, n);
    chk(n == LAT, "R8 no hold", n, LAT);
    wait_sig(1, SC + 10, n);
    close_meas(0);
  endtask

  task automatic t_interval;
    int n, hits;
    mode_interval = 1'b1; hold_len = 0;
    fire(0);
    count_dec(8, hits);
    chk(hits == 0, "R10 trigger ignored", hits, 0);
    fire(2);
    count_dec(8, hits);
    chk(hits == 0 && !gate, "R11 stop before start", hits, 0);
    open_meas(1);
    fire(1);
    count_dec(8, hits);
    chk(hits == 0 && gate, "R10 second start ignored", hits, 0);
    fire(0);
    count_dec(8, hits);
    chk(gate == 1'b1, "R10 trigger does not close", gate, 1);
    fire(2);
    wait_sig(2, 10, n);
    chk(n == LAT, "R10 stop closes", n, LAT);
    fire(2);
    count_dec(8, hits);
    chk(hits == 0 && !gate, "R11 stop while closed", hits, 0);
    mode_interval = 1'b0;
  endtask

  task automatic t_level;
    int rises;
    logic prev;
    mode_interval = 1'b0; hold_len = 0;
    rises = 0; prev = 1'b0;
    trig = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (dec_rst && !prev) rises++;
      prev = dec_rst;
    end
    chk(rises == 1, "R12 single start", rises, 1);
    chk(gate == 1'b1, "R12 level does not close", gate, 1);
    trig = 1'b0;
    repeat (4) @(negedge clk);
    close_meas(0);
  endtask

  task automatic t_manual;
    int n, hits;
    mode_interval = 1'b0; hold_len = 0;
    open_meas(0);
    fire(3);
    wait_sig(0, 10, n);
    chk(n == LAT, "R9 manual clear latency", n, LAT);
    chk(gate == 1'b0, "R9 gate closed by abort", gate, 0);
    hold_len = 50;
    open_meas(0);
    close_meas(0);
    fire(3);
    wait_sig(0, 10, n);
    chk(n == LAT, "R9 manual during hold", n, LAT);
    fire(0);
    wait_sig(0, 10, n);
    chk(n == LAT, "R9 hold aborted", n, LAT);
    repeat (5) @(negedge clk);
    fire(3);
    count_dec(SC + 10, hits);
    chk(gate == 1'b0, "R9 settle aborted", gate, 0);
    chk(hits == 1, "R9 one manual pulse", hits, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_auto();
    t_hold();
    t_hold_zero();
    t_interval();
    t_level();
    t_manual();
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule